// File: doc/BRIEF.md
# Serial Memory Write-Protect Unit

This block guards every write into a small serial memory. It holds the protection fields of the memory's status register: a two-bit protect level, a protect-enable bit and the write-enable latch. It also watches an external active-low write-protect pin. From these it reports, combinationally, whether a status-register write is allowed and whether a byte at a given array address may be written.

The protect level selects an upper part of the array that is read-only. Level 0 protects nothing, level 1 the top quarter, level 2 the top half and level 3 the whole array. Status-register protection is decided separately, from the enable bit, the pin and the latch.

A command decoder in front of this block raises one-cycle strobes. These strobes set or clear the latch and commit status or array writes. A permitted commit updates the registers on the next clock edge and ends the write by clearing the latch. A refused commit changes nothing.

Top module: `wp_guard`

## Requirements
- R1: After synchronous reset, `level_q` is 00, `lock_en_q` is 0 and `wel_q` is 0.
- R2: `wel_set_i` sets `wel_q` at the next edge and `wel_clr_i` clears it. When both are high, or when a permitted commit happens in the same cycle, the latch ends up clear.
- R3: `hw_locked_o` is 1 exactly when `lock_en_q` is 1 and `wp_n_i` is 0. It follows the pin in the same cycle.
- R4: `sr_write_ok_o` is 1 exactly when `wel_q` is 1 and `hw_locked_o` is 0.
- R5: A `sr_commit_i` pulse while `sr_write_ok_o` is 1 does three things at the next edge: it loads `sr_level_i` into `level_q`, loads `sr_lock_en_i` into `lock_en_q`, and clears `wel_q`.
- R6: A `sr_commit_i` pulse while `sr_write_ok_o` is 0 leaves `level_q`, `lock_en_q` and `wel_q` unchanged. In particular, a set enable bit cannot be cleared while the pin is low.
- R7: For level 00 no address is protected. For 01, addresses at or above 3/4 of the array depth are protected (0x300–0x3FF at depth 1024). For 10, addresses at or above half the depth are protected (0x200–0x3FF). For 11, every address is protected. `arr_write_ok_o` is `wel_q` AND NOT protected.
- R8: An `arr_commit_i` pulse while `arr_write_ok_o` is 1 clears `wel_q` at the next edge. While `arr_write_ok_o` is 0, the pulse leaves `wel_q` unchanged.
- R9: `arr_write_ok_o` does not depend on `wp_n_i` or `lock_en_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n_i | input | 1 | External write-protect pin, active low |
| wel_set_i | input | 1 | Strobe: set write-enable latch |
| wel_clr_i | input | 1 | Strobe: clear write-enable latch |
| sr_commit_i | input | 1 | Strobe: commit status-register write |
| sr_level_i | input | 2 | New protect level for the status write |
| sr_lock_en_i | input | 1 | New protect-enable bit for the status write |
| arr_addr_i | input | ADDR_W | Target array byte address |
| arr_commit_i | input | 1 | Strobe: commit array write |
| level_q | output | 2 | Current protect level |
| lock_en_q | output | 1 | Current protect-enable bit |
| wel_q | output | 1 | Current write-enable latch |
| hw_locked_o | output | 1 | Hardware protection active |
| sr_write_ok_o | output | 1 | Status-register write permitted |
| arr_write_ok_o | output | 1 | Array write to `arr_addr_i` permitted |

## Verification
The three permission outputs are combinational. The bench checks them one time unit after the inputs change, with no clock edge in between. Register results (`level_q`, `lock_en_q`, `wel_q`) are due one edge after the strobe. The bench drives strobes just after a falling edge and samples on the following falling edge, so exactly one rising edge separates stimulus and check. Permission decisions made on the stimulus cycle are confirmed through the register state seen on the next cycle.

// File: rtl/wp_guard_pkg.sv
// Package: shared types for the write-protect unit.
// Assumes: the protect level is a two-bit code, 0 = none .. 3 = whole array.
package wp_guard_pkg;

    // Protect level encoding, held in the status register.
    typedef enum logic [1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_ALL     = 2'b11
    } prot_level_e;

    // Protection fields of the status register.
    typedef struct packed {
        logic [1:0] level;
        logic       lock_en;
    } prot_cfg_t;

endpackage

// File: rtl/wp_guard_status_regs.sv
// Module: holds protect level, protect-enable bit and write-enable latch.
// Assumes: the permission inputs come from combinational logic fed by these
// same registers; strobes are one cycle wide; reset is synchronous, active low.
module wp_guard_status_regs
    import wp_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wel_set_i,
    input  logic      wel_clr_i,
    input  logic      sr_commit_i,
    input  logic      sr_ok_i,
    input  logic      arr_commit_i,
    input  logic      arr_ok_i,
    input  prot_cfg_t cfg_in_i,
    output prot_cfg_t cfg_q_o,
    output logic      wel_q_o
);

    logic sr_take;
    logic arr_take;
    logic wel_next;

    // Decide which commits are honoured this cycle.
    always_comb begin
        sr_take  = sr_commit_i && sr_ok_i;
        arr_take = arr_commit_i && arr_ok_i;
    end

    // Next latch value: any clearing source wins over a set.
    always_comb begin
        if (sr_take || arr_take || wel_clr_i)
            wel_next = 1'b0;
        else if (wel_set_i)
            wel_next = 1'b1;
        else
            wel_next = wel_q_o;
    end

    // Protection fields: load only on a permitted status commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q_o <= '{level: LVL_NONE, lock_en: 1'b0};
        else if (sr_take)
            cfg_q_o <= cfg_in_i;
    end

    // Write-enable latch register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel_q_o <= 1'b0;
        else
            wel_q_o <= wel_next;
    end

    // R2: a clear strobe always leaves the latch clear
    p_wel_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_i |=> !wel_q_o);

    // R5: permitted status commit loads fields and ends the write
    p_sr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_commit_i && sr_ok_i) |=> (!wel_q_o && cfg_q_o == $past(cfg_in_i)));

    // R6: refused status commit leaves the fields alone
    p_sr_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_commit_i && !sr_ok_i) |=> $stable(cfg_q_o));

    // R8: permitted array commit ends the write
    p_arr_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_commit_i && arr_ok_i) |=> !wel_q_o);

endmodule

// File: rtl/wp_guard_array_gate.sv
// Module: decides whether one array address lies in the protected upper
// region, and whether a byte write there is allowed.
// Assumes: ADDR_W >= 2; the region is the top 0, 1/4, 1/2 or all of the array.
module wp_guard_array_gate
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [1:0]        level_i,
    input  logic              wel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_hit_o,
    output logic              write_ok_o
);

    localparam int          BW       = ADDR_W + 1;
    localparam logic [BW-1:0] DEPTH  = BW'(1) << ADDR_W;
    localparam logic [BW-1:0] HALF   = DEPTH >> 1;
    localparam logic [BW-1:0] QUART3 = HALF + (DEPTH >> 2);

    logic [BW-1:0] base;

    // Lowest protected address for the current level (DEPTH = none).
    always_comb begin
        case (prot_level_e'(level_i))
            LVL_QUARTER: base = QUART3;
            LVL_HALF:    base = HALF;
            LVL_ALL:     base = '0;
            default:     base = DEPTH;
        endcase
    end

    // Compare the address against the region base and gate with the latch.
    always_comb begin
        prot_hit_o = ({1'b0, addr_i} >= base);
        write_ok_o = wel_i && !prot_hit_o;
    end

endmodule

// File: rtl/wp_guard.sv
// Module: write-protect unit of a serial memory status register.
// Combines the pin, the protect-enable bit and the latch into status-write
// permission, and the protect level and latch into array-write permission.
// Assumes: strobes come from a command decoder, one cycle wide; wp_n_i is
// already synchronised to clk.
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              sr_commit_i,
    input  logic [1:0]        sr_level_i,
    input  logic              sr_lock_en_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              arr_commit_i,
    output logic [1:0]        level_q,
    output logic              lock_en_q,
    output logic              wel_q,
    output logic              hw_locked_o,
    output logic              sr_write_ok_o,
    output logic              arr_write_ok_o
);

    prot_cfg_t cfg_q;
    prot_cfg_t cfg_in;
    logic      prot_hit;

    // Pack the requested status fields.
    always_comb begin
        cfg_in.level   = sr_level_i;
        cfg_in.lock_en = sr_lock_en_i;
    end

    // Hardware lock and status-register permission.
    always_comb begin
        hw_locked_o   = cfg_q.lock_en && !wp_n_i;
        sr_write_ok_o = wel_q && !hw_locked_o;
        level_q       = cfg_q.level;
        lock_en_q     = cfg_q.lock_en;
    end

    wp_guard_status_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wel_set_i    (wel_set_i),
        .wel_clr_i    (wel_clr_i),
        .sr_commit_i  (sr_commit_i),
        .sr_ok_i      (sr_write_ok_o),
        .arr_commit_i (arr_commit_i),
        .arr_ok_i     (arr_write_ok_o),
        .cfg_in_i     (cfg_in),
        .cfg_q_o      (cfg_q),
        .wel_q_o      (wel_q)
    );

    wp_guard_array_gate #(.ADDR_W(ADDR_W)) u_gate (
        .level_i    (cfg_q.level),
        .wel_i      (wel_q),
        .addr_i     (arr_addr_i),
        .prot_hit_o (prot_hit),
        .write_ok_o (arr_write_ok_o)
    );

    // R4: a hardware lock always refuses status writes
    p_lock_blocks_sr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_locked_o |-> !sr_write_ok_o);

    // R7: whole-array level refuses every array write
    p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == 2'b11) |-> (!arr_write_ok_o && prot_hit));

    // R6: a set enable bit survives while the pin is held low
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en_q && !wp_n_i) |=> lock_en_q);

endmodule

// File: tb/wp_guard_tb_top.sv
// Bench: vector table for the address decode, then directed tests.
module wp_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wp_n, wset, wclr, sr_c, sr_en, arr_c;
    logic [1:0]    sr_lvl;
    logic [AW-1:0] addr;
    logic [1:0]    level_q;
    logic          lock_en_q, wel_q, hw_locked, sr_ok, arr_ok;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_guard #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wel_set_i(wset),
        .wel_clr_i(wclr), .sr_commit_i(sr_c), .sr_level_i(sr_lvl),
        .sr_lock_en_i(sr_en), .arr_addr_i(addr), .arr_commit_i(arr_c),
        .level_q(level_q), .lock_en_q(lock_en_q), .wel_q(wel_q),
        .hw_locked_o(hw_locked), .sr_write_ok_o(sr_ok),
        .arr_write_ok_o(arr_ok)
    );

    // Vector: {level[12:11], addr[10:1], expected arr_write_ok with wel set [0]}
    localparam logic [12:0] VEC [10] = '{
        {2'b00, 10'h3FF, 1'b1},
        {2'b00, 10'h000, 1'b1},
        {2'b01, 10'h000, 1'b1},
        {2'b01, 10'h2FF, 1'b1},
        {2'b01, 10'h300, 1'b0},
        {2'b01, 10'h3FF, 1'b0},
        {2'b10, 10'h1FF, 1'b1},
        {2'b10, 10'h200, 1'b0},
        {2'b11, 10'h000, 1'b0},
        {2'b11, 10'h3FF, 1'b0}
    };

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic idle();
        wset = 0; wclr = 0; sr_c = 0; arr_c = 0;
    endtask

    // One clock: inputs held since last falling edge, sample at next one.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic write_sr(input logic [1:0] lvl, input logic en);
        wset = 1; step();
        sr_lvl = lvl; sr_en = en; sr_c = 1; step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wp_n = 1; sr_lvl = 0; sr_en = 0; addr = 0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(level_q, 0, "R1 level after reset");
        check(lock_en_q, 0, "R1 enable after reset");
        check(wel_q, 0, "R1 latch after reset");
        check(sr_ok, 0, "R4 status write refused with latch clear");
        check(arr_ok, 0, "R7 array write refused with latch clear");

        // Vector walk over the address decode (R7)
        foreach (VEC[i]) begin
            write_sr(VEC[i][12:11], 1'b0);
            check(level_q, VEC[i][12:11], "R5 level loaded");
            check(wel_q, 0, "R5 latch cleared by commit");
            wset = 1; step();
            addr = VEC[i][10:1]; #1;
            check(arr_ok, VEC[i][0], "R7 address decode");
        end

        // R8: refused array commit (level 11, latch set) keeps latch
        arr_c = 1; step();
        check(wel_q, 1, "R8 refused array commit keeps latch");

        // R2: both strobes -> clear wins
        write_sr(2'b00, 1'b0);
        wset = 1; wclr = 1; step();
        check(wel_q, 0, "R2 clear wins over set");
        wset = 1; step();
        check(wel_q, 1, "R2 set strobe");
        wclr = 1; step();
        check(wel_q, 0, "R2 clear strobe");

        // R6: commit with latch clear is ignored
        sr_lvl = 2'b11; sr_en = 1; sr_c = 1; step();
        check(level_q, 0, "R6 no-latch commit keeps level");
        check(lock_en_q, 0, "R6 no-latch commit keeps enable");

        // Lock with pin low (R3, R4, R6, R9)
        write_sr(2'b00, 1'b1);
        check(lock_en_q, 1, "R5 enable loaded");
        wp_n = 0; #1;
        check(hw_locked, 1, "R3 locked when enabled and pin low");
        wset = 1; step();
        check(sr_ok, 0, "R4 status refused while locked");
        sr_lvl = 2'b10; sr_en = 0; sr_c = 1; step();
        check(lock_en_q, 1, "R6 enable cannot clear while pin low");
        check(level_q, 0, "R6 level unchanged while locked");
        check(wel_q, 1, "R6 latch unchanged by refused commit");
        addr = 10'h3FF; #1;
        check(arr_ok, 1, "R9 array write unaffected by lock");
        arr_c = 1; step();
        check(wel_q, 0, "R8 permitted array commit clears latch");

        // R2: permitted commit in same cycle as set leaves latch clear
        wset = 1; step();
        wset = 1; arr_c = 1; step();
        check(wel_q, 0, "R2 commit clear wins over set");

        // Release pin (R3), clear enable (R5)
        wp_n = 1; #1;
        check(hw_locked, 0, "R3 pin high releases lock");
        write_sr(2'b01, 1'b0);
        check(lock_en_q, 0, "R5 enable cleared with pin high");
        check(level_q, 1, "R5 level loaded with pin high");
        wp_n = 0; #1;
        check(hw_locked, 0, "R3 pin low with enable clear is not locked");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

endmodule